// File: doc/BRIEF.md
# Banked Memory Map Decoder

This block sits between an 8-bit CPU with a 16-bit address bus and the memories and peripherals around it. It works out, from the address and the current mode, which device owns each access, drives that device's select and write-enable, and gathers the read data back onto the CPU bus. Boot ROM, main RAM, video RAM, an extension ROM, a parallel port and a counter/timer are all served from one 64 KB map.

Three small registers hold the display and mapping modes. A swap flag exchanges the lowest 4 KB page with the 4 KB page at 0xC000. With swap set, the CPU runs out of RAM at address zero, and the boot ROM moves up to 0xC000. A reverse-video flag and an 8-bit scroll offset are also kept for the display logic. All three change only when the CPU reads particular addresses inside the I/O window, so plain load instructions can switch modes. The same window returns a status byte that carries the horizontal-blank and tempo inputs.

Decoding is combinational. The mode registers update on the clock edge at which the read strobe is active, so their effect is seen from the next cycle on.

Top module: `bank_map_decoder`

## Requirements
- R1: With swap clear, addresses 0x0000–0x0FFF assert boot_cs and never assert ram_we. Addresses 0xC000–0xCFFF assert ram_cs with ram_addr equal to the CPU address.
- R2: With swap set, 0x0000–0x0FFF asserts ram_cs with ram_addr = 0xC000 plus the low 12 address bits, and writes there assert ram_we. 0xC000–0xCFFF asserts boot_cs, and ram_we stays low.
- R3: 0x1000–0xBFFF always asserts ram_cs with ram_addr equal to the CPU address. 0xD000–0xD7FF asserts vid_cs, and vid_we follows cpu_wr.
- R4: 0xE000–0xE003 asserts pport_cs and 0xE004–0xE007 asserts timer_cs. dev_sel_addr carries address bits 1..0, and cpu_rdata returns that device's read data.
- R5: 0xE800–0xEFFF asserts ext_cs and returns ext_rdata. Reads of 0xD800–0xDFFF, of 0xF000–0xFFFF, and of any I/O-window address that selects no device return 0xFF with no select asserted.
- R6: A read of 0xE00C sets swap_on and a read of 0xE010 clears it, both effective in the following cycle. Writes to these addresses change nothing. Reset clears swap_on.
- R7: A read of 0xE008 returns hblank_in in bit 7, tempo_in in bit 0 and ones in bits 6..1.
- R8: A read of 0xE015 sets reverse_on and a read of 0xE014 clears it, effective in the following cycle. Reset clears reverse_on.
- R9: A read of any address 0xE200–0xE2FF loads address bits 7..0 into scroll_ofs in the following cycle. Writes there leave it unchanged. Reset sets it to 0.
- R10: At most one of the six selects is active in any cycle, and cpu_rdata returns boot_rdata, ram_rdata or vid_rdata whenever that device is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | CPU address |
| cpu_rd | input | 1 | Read strobe |
| cpu_wr | input | 1 | Write strobe |
| tempo_in | input | 1 | Tempo square wave level |
| hblank_in | input | 1 | Horizontal-blank flag |
| boot_rdata | input | 8 | Boot ROM read data |
| ram_rdata | input | 8 | Main RAM read data |
| vid_rdata | input | 8 | Video RAM read data |
| ext_rdata | input | 8 | Extension ROM read data |
| pport_rdata | input | 8 | Parallel port read data |
| timer_rdata | input | 8 | Counter/timer read data |
| boot_cs | output | 1 | Boot ROM select |
| ram_cs | output | 1 | Main RAM select |
| ram_we | output | 1 | Main RAM write enable |
| ram_addr | output | 16 | Physical RAM address after swap |
| vid_cs | output | 1 | Video RAM select |
| vid_we | output | 1 | Video RAM write enable |
| ext_cs | output | 1 | Extension ROM select |
| pport_cs | output | 1 | Parallel port select |
| timer_cs | output | 1 | Counter/timer select |
| dev_sel_addr | output | 2 | Register index for the peripherals |
| cpu_rdata | output | 8 | Read data to the CPU |
| swap_on | output | 1 | Swap mode flag |
| reverse_on | output | 1 | Reverse-video flag |
| scroll_ofs | output | 8 | Scroll offset |

## Verification
The bench walks the page boundaries: 0x0FFF against 0x1000, 0xBFFF against 0xC000, 0xD7FF against 0xD800, and the gap inside the I/O window at 0xE009. A decoder with an off-by-one range would show a wrong select or a data byte other than 0xFF at one of these addresses. It writes to the ROM pages both with swap clear and with swap set, so a design that keeps the write enable on the ROM page, or forgets to move the RAM physical address, is caught. Writes to the mode-switch and scroll addresses check that a design triggering on any access, and not only on reads, would change a flag it must leave alone. A reset taken while all three mode registers are non-zero checks that each one returns to its reset value.

// File: rtl/amd_pkg.sv
`timescale 1ns/1ps
package amd_pkg;
  localparam int AW       = 16;
  localparam int PAGE_W   = 4;
  localparam int PAGE_LSB = AW - PAGE_W;

  localparam logic [PAGE_W-1:0] PG_LOW  = 4'h0;
  localparam logic [PAGE_W-1:0] PG_HIGH = 4'hC;
  localparam logic [PAGE_W-1:0] PG_VID  = 4'hD;
  localparam logic [PAGE_W-1:0] PG_IO   = 4'hE;
  localparam logic [PAGE_W-1:0] PG_TOP  = 4'hF;

  localparam logic [10:0] IO_STAT     = 11'h008;
  localparam logic [10:0] IO_SWAP_SET = 11'h00C;
  localparam logic [10:0] IO_SWAP_CLR = 11'h010;
  localparam logic [10:0] IO_INV_CLR  = 11'h014;
  localparam logic [10:0] IO_INV_SET  = 11'h015;
  localparam logic [2:0]  IO_SCRL_HI  = 3'b010;

  typedef enum logic [2:0] {
    RGN_NONE, RGN_BOOT, RGN_RAM, RGN_VID, RGN_IOW, RGN_EXT
  } rgn_e;

  typedef enum logic [3:0] {
    IOF_NONE, IOF_PPORT, IOF_TIMER, IOF_STAT, IOF_SWAP_SET,
    IOF_SWAP_CLR, IOF_INV_CLR, IOF_INV_SET, IOF_SCRL
  } iof_e;

  typedef struct packed {
    rgn_e          rgn;
    iof_e          iof;
    logic [AW-1:0] ram_addr;
  } dec_t;
endpackage

// File: rtl/amd_region_decode.sv
`timescale 1ns/1ps
module amd_region_decode
  import amd_pkg::*;
(
  input  logic [AW-1:0] addr,
  input  logic          swap,
  output dec_t          dec
);
  logic [PAGE_W-1:0] page;
  logic [10:0]       io_off;

  assign page   = addr[AW-1 -: PAGE_W];
  assign io_off = addr[10:0];

  always_comb begin
    dec.rgn      = RGN_NONE;
    dec.iof      = IOF_NONE;
    dec.ram_addr = addr;
    case (page)
      PG_LOW: begin
        if (swap) begin
          dec.rgn      = RGN_RAM;
          dec.ram_addr = {PG_HIGH, addr[PAGE_LSB-1:0]};
        end else begin
          dec.rgn = RGN_BOOT;
        end
      end
      PG_HIGH: dec.rgn = swap ? RGN_BOOT : RGN_RAM;
      PG_VID:  dec.rgn = addr[11] ? RGN_NONE : RGN_VID;
      PG_IO:   dec.rgn = addr[11] ? RGN_EXT : RGN_IOW;
      PG_TOP:  dec.rgn = RGN_NONE;
      default: dec.rgn = RGN_RAM;
    endcase

    if (dec.rgn == RGN_IOW) begin
      if (io_off[10:2] == 9'd0)             dec.iof = IOF_PPORT;
      else if (io_off[10:2] == 9'd1)        dec.iof = IOF_TIMER;
      else if (io_off == IO_STAT)           dec.iof = IOF_STAT;
      else if (io_off == IO_SWAP_SET)       dec.iof = IOF_SWAP_SET;
      else if (io_off == IO_SWAP_CLR)       dec.iof = IOF_SWAP_CLR;
      else if (io_off == IO_INV_CLR)        dec.iof = IOF_INV_CLR;
      else if (io_off == IO_INV_SET)        dec.iof = IOF_INV_SET;
      else if (io_off[10:8] == IO_SCRL_HI)  dec.iof = IOF_SCRL;
    end
  end
endmodule

// File: rtl/amd_mode_regs.sv
`timescale 1ns/1ps
module amd_mode_regs
  import amd_pkg::*;
#(
  parameter int SW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd,
  input  iof_e          iof,
  input  logic [SW-1:0] addr_lo,
  output logic          rst_q_n,
  output logic          swap_q,
  output logic          inv_q,
  output logic [SW-1:0] scrl_q
);
  logic [1:0]    rsync;
  logic          upd;
  logic          swap_d;
  logic          inv_d;
  logic [SW-1:0] scrl_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync <= 2'b00;
    else        rsync <= {rsync[0], 1'b1};
  end
  assign rst_q_n = rsync[1];

  always_comb begin
    swap_d = swap_q;
    inv_d  = inv_q;
    scrl_d = scrl_q;
    upd    = 1'b0;
    if (rd) begin
      case (iof)
        IOF_SWAP_SET: begin swap_d = 1'b1;    upd = 1'b1; end
        IOF_SWAP_CLR: begin swap_d = 1'b0;    upd = 1'b1; end
        IOF_INV_SET:  begin inv_d  = 1'b1;    upd = 1'b1; end
        IOF_INV_CLR:  begin inv_d  = 1'b0;    upd = 1'b1; end
        IOF_SCRL:     begin scrl_d = addr_lo; upd = 1'b1; end
        default:      upd = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      swap_q <= 1'b0;
      inv_q  <= 1'b0;
      scrl_q <= '0;
    end else if (upd) begin
      swap_q <= swap_d;
      inv_q  <= inv_d;
      scrl_q <= scrl_d;
    end
  end
endmodule

// File: rtl/amd_rdata_mux.sv
`timescale 1ns/1ps
module amd_rdata_mux
  import amd_pkg::*;
#(
  parameter int DW = 8
) (
  input  rgn_e          rgn,
  input  iof_e          iof,
  input  logic [DW-1:0] boot_d,
  input  logic [DW-1:0] ram_d,
  input  logic [DW-1:0] vid_d,
  input  logic [DW-1:0] ext_d,
  input  logic [DW-1:0] pport_d,
  input  logic [DW-1:0] timer_d,
  input  logic          tempo,
  input  logic          hblank,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] status;
  assign status = {hblank, {(DW-2){1'b1}}, tempo};

  always_comb begin
    rdata = '1;
    case (rgn)
      RGN_BOOT: rdata = boot_d;
      RGN_RAM:  rdata = ram_d;
      RGN_VID:  rdata = vid_d;
      RGN_EXT:  rdata = ext_d;
      RGN_IOW: begin
        case (iof)
          IOF_PPORT: rdata = pport_d;
          IOF_TIMER: rdata = timer_d;
          IOF_STAT:  rdata = status;
          default:   rdata = '1;
        endcase
      end
      default: rdata = '1;
    endcase
  end
endmodule

// File: rtl/bank_map_decoder.sv
`timescale 1ns/1ps
module bank_map_decoder
  import amd_pkg::*;
#(
  parameter int DW = 8,
  parameter int SW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [15:0]   cpu_addr,
  input  logic          cpu_rd,
  input  logic          cpu_wr,
  input  logic          tempo_in,
  input  logic          hblank_in,
  input  logic [DW-1:0] boot_rdata,
  input  logic [DW-1:0] ram_rdata,
  input  logic [DW-1:0] vid_rdata,
  input  logic [DW-1:0] ext_rdata,
  input  logic [DW-1:0] pport_rdata,
  input  logic [DW-1:0] timer_rdata,
  output logic          boot_cs,
  output logic          ram_cs,
  output logic          ram_we,
  output logic [15:0]   ram_addr,
  output logic          vid_cs,
  output logic          vid_we,
  output logic          ext_cs,
  output logic          pport_cs,
  output logic          timer_cs,
  output logic [1:0]    dev_sel_addr,
  output logic [DW-1:0] cpu_rdata,
  output logic          swap_on,
  output logic          reverse_on,
  output logic [SW-1:0] scroll_ofs
);
  dec_t dec;
  logic rst_q_n;

  amd_region_decode u_dec (
    .addr (cpu_addr),
    .swap (swap_on),
    .dec  (dec)
  );

  amd_mode_regs #(.SW(SW)) u_modes (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd      (cpu_rd),
    .iof     (dec.iof),
    .addr_lo (cpu_addr[SW-1:0]),
    .rst_q_n (rst_q_n),
    .swap_q  (swap_on),
    .inv_q   (reverse_on),
    .scrl_q  (scroll_ofs)
  );

  amd_rdata_mux #(.DW(DW)) u_mux (
    .rgn     (dec.rgn),
    .iof     (dec.iof),
    .boot_d  (boot_rdata),
    .ram_d   (ram_rdata),
    .vid_d   (vid_rdata),
    .ext_d   (ext_rdata),
    .pport_d (pport_rdata),
    .timer_d (timer_rdata),
    .tempo   (tempo_in),
    .hblank  (hblank_in),
    .rdata   (cpu_rdata)
  );

  assign boot_cs      = (dec.rgn == RGN_BOOT);
  assign ram_cs       = (dec.rgn == RGN_RAM);
  assign vid_cs       = (dec.rgn == RGN_VID);
  assign ext_cs       = (dec.rgn == RGN_EXT);
  assign pport_cs     = (dec.iof == IOF_PPORT);
  assign timer_cs     = (dec.iof == IOF_TIMER);
  assign ram_we       = ram_cs & cpu_wr;
  assign vid_we       = vid_cs & cpu_wr;
  assign ram_addr     = dec.ram_addr;
  assign dev_sel_addr = cpu_addr[1:0];
endmodule

// File: rtl/amd_checker.sv
`timescale 1ns/1ps
module amd_checker (
  input logic        clk,
  input logic        rst_q_n,
  input logic [15:0] cpu_addr,
  input logic        cpu_rd,
  input logic        cpu_wr,
  input logic        tempo_in,
  input logic        hblank_in,
  input logic        boot_cs,
  input logic        ram_cs,
  input logic        ram_we,
  input logic [15:0] ram_addr,
  input logic        vid_cs,
  input logic        vid_we,
  input logic        ext_cs,
  input logic        pport_cs,
  input logic        timer_cs,
  input logic [7:0]  cpu_rdata,
  input logic        swap_on,
  input logic [7:0]  scroll_ofs
);
  // R1
  rom_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    boot_cs |-> (!ram_we && !vid_we));

  // R2
  swap_lowpage_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (swap_on && cpu_addr[15:12] == 4'h0) |-> (ram_cs && ram_addr[15:12] == 4'hC && ram_addr[11:0] == cpu_addr[11:0]));

  // R6
  swap_set_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (cpu_rd && cpu_addr == 16'hE00C) |=> swap_on);

  // R6
  swap_clr_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (cpu_rd && cpu_addr == 16'hE010) |=> !swap_on);

  // R6
  swap_hold_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    !(cpu_rd && (cpu_addr == 16'hE00C || cpu_addr == 16'hE010)) |=> $stable(swap_on));

  // R7
  status_byte_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (cpu_addr == 16'hE008) |-> (cpu_rdata == {hblank_in, 6'h3F, tempo_in}));

  // R9
  scroll_load_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (cpu_rd && cpu_addr[15:8] == 8'hE2) |=> (scroll_ofs == $past(cpu_addr[7:0])));

  // R10
  select_onehot_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    $onehot0({boot_cs, ram_cs, vid_cs, ext_cs, pport_cs, timer_cs}));
endmodule

bind bank_map_decoder amd_checker chk (
  .clk        (clk),
  .rst_q_n    (rst_q_n),
  .cpu_addr   (cpu_addr),
  .cpu_rd     (cpu_rd),
  .cpu_wr     (cpu_wr),
  .tempo_in   (tempo_in),
  .hblank_in  (hblank_in),
  .boot_cs    (boot_cs),
  .ram_cs     (ram_cs),
  .ram_we     (ram_we),
  .ram_addr   (ram_addr),
  .vid_cs     (vid_cs),
  .vid_we     (vid_we),
  .ext_cs     (ext_cs),
  .pport_cs   (pport_cs),
  .timer_cs   (timer_cs),
  .cpu_rdata  (cpu_rdata),
  .swap_on    (swap_on),
  .scroll_ofs (scroll_ofs)
);

// File: tb/bank_map_decoder_test.sv
`timescale 1ns/1ps
module bank_map_decoder_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_addr = 16'h1000;
  logic        cpu_rd = 1'b0;
  logic        cpu_wr = 1'b0;
  logic        tempo_in = 1'b0;
  logic        hblank_in = 1'b0;
  logic [7:0]  boot_rdata  = 8'hA1;
  logic [7:0]  ram_rdata   = 8'hB2;
  logic [7:0]  vid_rdata   = 8'hC3;
  logic [7:0]  ext_rdata   = 8'hD4;
  logic [7:0]  pport_rdata = 8'h5E;
  logic [7:0]  timer_rdata = 8'h6F;
  logic        boot_cs, ram_cs, ram_we, vid_cs, vid_we, ext_cs, pport_cs, timer_cs;
  logic [15:0] ram_addr;
  logic [1:0]  dev_sel_addr;
  logic [7:0]  cpu_rdata;
  logic        swap_on, reverse_on;
  logic [7:0]  scroll_ofs;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk; // 50 MHz

  bank_map_decoder uut (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
    .tempo_in(tempo_in), .hblank_in(hblank_in),
    .boot_rdata(boot_rdata), .ram_rdata(ram_rdata), .vid_rdata(vid_rdata),
    .ext_rdata(ext_rdata), .pport_rdata(pport_rdata), .timer_rdata(timer_rdata),
    .boot_cs(boot_cs), .ram_cs(ram_cs), .ram_we(ram_we), .ram_addr(ram_addr),
    .vid_cs(vid_cs), .vid_we(vid_we), .ext_cs(ext_cs), .pport_cs(pport_cs),
    .timer_cs(timer_cs), .dev_sel_addr(dev_sel_addr), .cpu_rdata(cpu_rdata),
    .swap_on(swap_on), .reverse_on(reverse_on), .scroll_ofs(scroll_ofs)
  );

  typedef struct {
    string       tag;
    logic [5:0]  sel;   // {boot, ram, vid, ext, pport, timer}
    logic [1:0]  we;    // {ram_we, vid_we}
    logic [7:0]  rdata;
    logic [15:0] raddr;
    logic [1:0]  daddr;
    logic        sw;
    logic        rv;
    logic [7:0]  sc;
  } exp_t;

  exp_t q[$];
  logic       m_sw = 1'b0;
  logic       m_rv = 1'b0;
  logic [7:0] m_sc = 8'h00;

  task automatic chk(input string tag, input string what, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  function automatic exp_t model(input logic [15:0] a, input logic w, input logic th, input logic hb);
    exp_t e;
    e.sel = 6'b0; e.we = 2'b0; e.rdata = 8'hFF; e.raddr = a; e.daddr = a[1:0];
    e.sw = m_sw; e.rv = m_rv; e.sc = m_sc; e.tag = "";
    if (a < 16'h1000) begin
      if (m_sw) begin e.sel = 6'b010000; e.raddr = 16'hC000 + a; end
      else e.sel = 6'b100000;
    end else if (a < 16'hC000) e.sel = 6'b010000;
    else if (a < 16'hD000) e.sel = m_sw ? 6'b100000 : 6'b010000;
    else if (a < 16'hD800) e.sel = 6'b001000;
    else if (a < 16'hE000) e.sel = 6'b000000;
    else if (a < 16'hE800) begin
      if (a <= 16'hE003) e.sel = 6'b000010;
      else if (a <= 16'hE007) e.sel = 6'b000001;
      else if (a == 16'hE008) e.rdata = {hb, 6'b111111, th};
    end else if (a < 16'hF000) e.sel = 6'b000100;
    case (e.sel)
      6'b100000: e.rdata = boot_rdata;
      6'b010000: e.rdata = ram_rdata;
      6'b001000: e.rdata = vid_rdata;
      6'b000100: e.rdata = ext_rdata;
      6'b000010: e.rdata = pport_rdata;
      6'b000001: e.rdata = timer_rdata;
      default: ;
    endcase
    e.we = {e.sel[4] & w, e.sel[3] & w};
    return e;
  endfunction

  // Driver: one access per cycle, expectation pushed to the scoreboard.
  task automatic op(input logic [15:0] a, input logic r, input logic w, input string tag,
                    input logic th = 1'b0, input logic hb = 1'b0);
    exp_t e;
    @(negedge clk);
    cpu_addr = a; cpu_rd = r; cpu_wr = w; tempo_in = th; hblank_in = hb;
    e = model(a, w, th, hb);
    e.tag = tag;
    q.push_back(e);
    if (r) begin
      if (a == 16'hE00C) m_sw = 1'b1;
      if (a == 16'hE010) m_sw = 1'b0;
      if (a == 16'hE014) m_rv = 1'b0;
      if (a == 16'hE015) m_rv = 1'b1;
      if (a[15:8] == 8'hE2) m_sc = a[7:0];
    end
  endtask

  // Monitor: compares each cycle's outputs with the queued expectation.
  initial begin
    exp_t e;
    forever begin
      @(negedge clk);
      #5;
      if (q.size() > 0) begin
        e = q.pop_front();
        chk(e.tag, "selects", {10'd0, boot_cs, ram_cs, vid_cs, ext_cs, pport_cs, timer_cs}, {10'd0, e.sel});
        chk(e.tag, "write_en", {14'd0, ram_we, vid_we}, {14'd0, e.we});
        chk(e.tag, "rdata", {8'd0, cpu_rdata}, {8'd0, e.rdata});
        if (e.sel[4]) chk(e.tag, "ram_addr", ram_addr, e.raddr);
        if (e.sel[1] | e.sel[0]) chk(e.tag, "dev_addr", {14'd0, dev_sel_addr}, {14'd0, e.daddr});
        chk(e.tag, "swap", {15'd0, swap_on}, {15'd0, e.sw});
        chk(e.tag, "reverse", {15'd0, reverse_on}, {15'd0, e.rv});
        chk(e.tag, "scroll", {8'd0, scroll_ofs}, {8'd0, e.sc});
      end
    end
  end

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog act=running exp=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #5;
    chk("R6", "reset swap", {15'd0, swap_on}, 16'd0);
    chk("R8", "reset reverse", {15'd0, reverse_on}, 16'd0);
    chk("R9", "reset scroll", {8'd0, scroll_ofs}, 16'd0);

    op(16'h0000, 1, 0, "R1");
    op(16'h0FFF, 1, 0, "R1");
    op(16'h0123, 0, 1, "R1");
    op(16'hC456, 1, 0, "R1");
    op(16'hC456, 0, 1, "R1");
    op(16'h1000, 1, 0, "R3");
    op(16'h5000, 0, 1, "R3");
    op(16'hBFFF, 1, 0, "R3");
    op(16'hD123, 0, 1, "R3");
    op(16'hD7FF, 1, 0, "R10");
    op(16'hD800, 1, 0, "R5");
    op(16'hDFFF, 0, 1, "R5");
    op(16'hF000, 1, 0, "R5");
    op(16'hFFFF, 1, 0, "R5");
    op(16'hE009, 1, 0, "R5");
    op(16'hE7FF, 1, 0, "R5");
    op(16'hE800, 1, 0, "R5");
    op(16'hEFFF, 1, 0, "R5");
    op(16'hE000, 1, 0, "R4");
    op(16'hE002, 0, 1, "R4");
    op(16'hE005, 1, 0, "R4");
    op(16'hE007, 1, 0, "R4");
    op(16'hE008, 1, 0, "R7", 1'b1, 1'b0);
    op(16'hE008, 1, 0, "R7", 1'b0, 1'b1);
    op(16'hE008, 1, 0, "R7", 1'b1, 1'b1);
    op(16'hE00C, 0, 1, "R6");
    op(16'h0123, 1, 0, "R6");
    op(16'hE00C, 1, 0, "R6");
    op(16'h0123, 1, 0, "R2");
    op(16'h0FFF, 0, 1, "R2");
    op(16'hC010, 1, 0, "R2");
    op(16'hC010, 0, 1, "R2");
    op(16'h4000, 1, 0, "R3");
    op(16'hE010, 0, 1, "R6");
    op(16'h0000, 1, 0, "R6");
    op(16'hE010, 1, 0, "R6");
    op(16'h0000, 1, 0, "R1");
    op(16'hE015, 1, 0, "R8");
    op(16'hE015, 0, 1, "R8");
    op(16'hE014, 0, 1, "R8");
    op(16'hE014, 1, 0, "R8");
    op(16'hE015, 1, 0, "R8");
    op(16'hE2A5, 1, 0, "R9");
    op(16'hE233, 0, 1, "R9");
    op(16'hE1FF, 1, 0, "R9");
    op(16'hE300, 1, 0, "R9");
    op(16'hE2FF, 1, 0, "R9");
    op(16'hE00C, 1, 0, "R6");
    op(16'h1000, 0, 0, "R6");
    op(16'h1000, 0, 0, "R6");

    @(negedge clk);
    cpu_rd = 1'b0; cpu_wr = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b0;
    m_sw = 1'b0; m_rv = 1'b0; m_sc = 8'h00;
    #5;
    chk("R6", "swap after reset", {15'd0, swap_on}, 16'd0);
    chk("R8", "reverse after reset", {15'd0, reverse_on}, 16'd0);
    chk("R9", "scroll after reset", {8'd0, scroll_ofs}, 16'd0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    op(16'h0456, 1, 0, "R1");
    op(16'hC456, 1, 0, "R1");
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule